// File: doc/BRIEF.md
# Dual-Bank Replicated Register File

This register file serves a two-slot long-instruction-word datapath. It keeps two separate banks of registers. Instruction slot 0 retires its results only into bank 0, and instruction slot 1 retires only into bank 1. Because no bank ever takes more than one write per cycle, each bank can be built purely from simple storage with one write port and one read port.

Read bandwidth comes from replication. Each bank holds one identical copy of its contents per read port, and every write to a bank goes to all of that bank's copies. Each read port has a bank-select bit and a register index. The port's output multiplexer picks copy p of whichever bank is selected, so any source operand can come from either bank. Reads are combinational and return data in the same cycle the index is presented. Writes take effect on the rising clock edge. Forwarding of results written in the same cycle is left to the surrounding pipeline.

Top module: `dual_bank_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every register of both banks to zero. Every read port returns zero after reset until a write occurs.
- R2: Write slot 0 (bits [0] of the write enable, index and data fields) updates only bank 0. Write slot 1 (bits [1] / the upper fields) updates only bank 1.
- R3: A value written at a rising edge is returned from the next cycle onward by every read port whose bank-select and index address that register.
- R4: Read data is combinational. A change of bank-select or index shows on the read output in the same cycle, with no clock edge needed.
- R5: A read of a register that is being written in the same cycle returns the value held before the write.
- R6: When a slot's write enable is low, its bank keeps all its contents, whatever the slot's index and data inputs are.
- R7: Bank-select 0 reads bank 0 and bank-select 1 reads bank 1. A write to one bank leaves the register with the same index in the other bank unchanged.
- R8: All read ports that address the same bank and index return identical data, because every copy of a bank stays equal.
- R9: Both slots may write in the same cycle, and both writes land independently, including when they use the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 2 | Per-slot write enable; bit s for slot s |
| wr_idx_i | input | 2*IDX_W | Slot s register index at [s*IDX_W +: IDX_W] |
| wr_data_i | input | 2*DATA_W | Slot s write data at [s*DATA_W +: DATA_W] |
| rd_bank_i | input | RD_PORTS | Per read port bank select; 0 = bank 0, 1 = bank 1 |
| rd_idx_i | input | RD_PORTS*IDX_W | Read port p index at [p*IDX_W +: IDX_W] |
| rd_data_o | output | RD_PORTS*DATA_W | Read port p data at [p*DATA_W +: DATA_W] |

## Verification
A write that reaches only some copies of a bank shows up as two read ports giving different values for the same bank and index. Such a mismatch can be seen one cycle after the faulty write, as soon as the copies are compared. A write routed to the wrong bank, or taken while the enable is low, corrupts a register. That register reads wrong on the first later read of it. The bench therefore reads every register through several port and bank combinations after each write phase. A stale or forwarding read path is exposed in the same cycle as the write it wrongly reflects.

// File: rtl/drf_pkg.sv
package drf_pkg;
   localparam int NUM_BANKS = 2;

   typedef enum logic {
      BANK_0 = 1'b0,
      BANK_1 = 1'b1
   } bank_sel_e;
endpackage

// File: rtl/drf_copy.sv
module drf_copy #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/drf_bank.sv
module drf_bank #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   parameter int NCOPY    = 3,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [IDX_W-1:0]        widx,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [NCOPY*IDX_W-1:0]  ridx,
   output logic [NCOPY*DATA_W-1:0] rdata
);
   for (genvar c = 0; c < NCOPY; c++) begin : g_copy
      drf_copy #(
         .DATA_W  (DATA_W),
         .NUM_REGS(NUM_REGS),
         .IDX_W   (IDX_W)
      ) u_copy (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (we),
         .widx (widx),
         .wdata(wdata),
         .ridx (ridx[c*IDX_W +: IDX_W]),
         .rdata(rdata[c*DATA_W +: DATA_W])
      );
   end
endmodule

// File: rtl/drf_read_sel.sv
module drf_read_sel
   import drf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NPORT  = 3
) (
   input  logic [NPORT-1:0]        sel,
   input  logic [NPORT*DATA_W-1:0] bank0_data,
   input  logic [NPORT*DATA_W-1:0] bank1_data,
   output logic [NPORT*DATA_W-1:0] rd_data
);
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      bank_sel_e s;
      assign s = bank_sel_e'(sel[p]);
      assign rd_data[p*DATA_W +: DATA_W] = (s == BANK_1) ?
         bank1_data[p*DATA_W +: DATA_W] : bank0_data[p*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
   import drf_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   parameter int RD_PORTS = 3,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_BANKS-1:0]       wr_en_i,
   input  logic [NUM_BANKS*IDX_W-1:0] wr_idx_i,
   input  logic [NUM_BANKS*DATA_W-1:0] wr_data_i,
   input  logic [RD_PORTS-1:0]        rd_bank_i,
   input  logic [RD_PORTS*IDX_W-1:0]  rd_idx_i,
   output logic [RD_PORTS*DATA_W-1:0] rd_data_o
);
   localparam int BANK_RD_W = RD_PORTS * DATA_W;

   if (NUM_REGS < 2) begin : g_bad_regs
      $error("dual_bank_regfile: NUM_REGS must be at least 2");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_pow2
      $error("dual_bank_regfile: NUM_REGS must be a power of two");
   end
   if (RD_PORTS < 1) begin : g_bad_ports
      $error("dual_bank_regfile: RD_PORTS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dual_bank_regfile: DATA_W must be at least 1");
   end

   logic [BANK_RD_W-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      drf_bank #(
         .DATA_W  (DATA_W),
         .NUM_REGS(NUM_REGS),
         .NCOPY   (RD_PORTS),
         .IDX_W   (IDX_W)
      ) u_bank (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (wr_en_i[b]),
         .widx (wr_idx_i[b*IDX_W +: IDX_W]),
         .wdata(wr_data_i[b*DATA_W +: DATA_W]),
         .ridx (rd_idx_i),
         .rdata(bank_rd[b])
      );
   end

   drf_read_sel #(
      .DATA_W(DATA_W),
      .NPORT (RD_PORTS)
   ) u_sel (
      .sel       (rd_bank_i),
      .bank0_data(bank_rd[0]),
      .bank1_data(bank_rd[1]),
      .rd_data   (rd_data_o)
   );
endmodule

// File: rtl/drf_checker.sv
module drf_checker #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 16,
   parameter int RD_PORTS = 3,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [1:0]                 wr_en_i,
   input logic [2*IDX_W-1:0]         wr_idx_i,
   input logic [2*DATA_W-1:0]        wr_data_i,
   input logic [RD_PORTS-1:0]        rd_bank_i,
   input logic [RD_PORTS*IDX_W-1:0]  rd_idx_i,
   input logic [RD_PORTS*DATA_W-1:0] rd_data_o
);
   // R1: a cycle spent in reset leaves every read output at zero
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (rd_data_o == '0));

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
      for (genvar b = 0; b < 2; b++) begin : g_bank
         // R3 / R2: last cycle's write to bank b is visible on port p
         p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(wr_en_i[b]) && (rd_bank_i[p] == b) &&
             (rd_idx_i[p*IDX_W +: IDX_W] == $past(wr_idx_i[b*IDX_W +: IDX_W])))
            |-> (rd_data_o[p*DATA_W +: DATA_W] == $past(wr_data_i[b*DATA_W +: DATA_W])));

         // R6: with its slot disabled, a bank's register cannot change
         p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!wr_en_i[b]) && (rd_bank_i[p] == b) &&
             ($past(rd_bank_i[p]) == b) && $stable(rd_idx_i[p*IDX_W +: IDX_W]))
            |-> $stable(rd_data_o[p*DATA_W +: DATA_W]));
      end

      if (p > 0) begin : g_cmp
         // R8: copies of a bank agree across read ports
         p_copies_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_bank_i[p] == rd_bank_i[0]) &&
             (rd_idx_i[p*IDX_W +: IDX_W] == rd_idx_i[0 +: IDX_W]))
            |-> (rd_data_o[p*DATA_W +: DATA_W] == rd_data_o[0 +: DATA_W]));
      end
   end
endmodule

bind dual_bank_regfile drf_checker #(
   .DATA_W  (DATA_W),
   .NUM_REGS(NUM_REGS),
   .RD_PORTS(RD_PORTS),
   .IDX_W   (IDX_W)
) u_chk (.*);

// File: tb/dual_bank_regfile_tb.sv
module dual_bank_regfile_tb;
   localparam int DW = 16;
   localparam int NR = 16;
   localparam int RD = 3;
   localparam int IW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      wr_en_i = '0;
   logic [2*IW-1:0] wr_idx_i = '0;
   logic [2*DW-1:0] wr_data_i = '0;
   logic [RD-1:0]   rd_bank_i = '0;
   logic [RD*IW-1:0] rd_idx_i = '0;
   logic [RD*DW-1:0] rd_data_o;

   dual_bank_regfile #(.DATA_W(DW), .NUM_REGS(NR), .RD_PORTS(RD)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
      .wr_data_i(wr_data_i), .rd_bank_i(rd_bank_i), .rd_idx_i(rd_idx_i),
      .rd_data_o(rd_data_o));

   always #2 clk = ~clk;   // 250 MHz

   typedef struct {
      int          port;
      logic [15:0] exp;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   event        sample_ev;
   logic [15:0] mdl [2][NR];
   int          n_checks = 0;
   int          n_fail = 0;
   bit          finished = 0;

   // Monitor: compares design outputs against queued expectations
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            exp_t it;
            logic [15:0] got;
            it  = sb_q.pop_front();
            got = rd_data_o[it.port*DW +: DW];
            n_checks++;
            if (got !== it.exp) begin
               n_fail++;
               $display("FAIL %s port %0d: actual %h expected %h", it.tag, it.port, got, it.exp);
            end
         end
      end
   end

   // Driver: applies one cycle, queues expected reads, updates the model
   task automatic step(input logic [1:0] we,
                       input logic [3:0] wi0, input logic [15:0] wd0,
                       input logic [3:0] wi1, input logic [15:0] wd1,
                       input logic [2:0] bs,
                       input logic [3:0] ri0, input logic [3:0] ri1, input logic [3:0] ri2,
                       input string tag);
      logic [3:0] ri [3];
      ri[0] = ri0; ri[1] = ri1; ri[2] = ri2;
      @(negedge clk);
      wr_en_i   = we;
      wr_idx_i  = {wi1, wi0};
      wr_data_i = {wd1, wd0};
      rd_bank_i = bs;
      rd_idx_i  = {ri2, ri1, ri0};
      #1;
      for (int p = 0; p < RD; p++) begin
         exp_t e;
         e.port = p;
         e.exp  = mdl[bs[p]][ri[p]];   // old value even if written this cycle (R5)
         e.tag  = tag;
         sb_q.push_back(e);
      end
      -> sample_ev;
      if (we[0]) mdl[0][wi0] = wd0;   // R2: slot 0 -> bank 0
      if (we[1]) mdl[1][wi1] = wd1;   // R2: slot 1 -> bank 1
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < NR; i++) mdl[b][i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: all registers read zero after reset
      for (int i = 0; i < NR; i++)
         step(2'b00, 4'(i), 16'hFFFF, 4'(i), 16'hFFFF, 3'b010, 4'(i), 4'(i), 4'(i), "R1");

      // R9 / R2: both slots write every cycle, sometimes at the same index
      for (int i = 0; i < NR; i++)
         step(2'b11, 4'(i), 16'(16'hA000 + i*37), 4'((i < 8) ? i : 15 - i + 8),
              16'(16'h5000 ^ (i*291)), 3'b101, 4'(i), 4'(15 - i), 4'(i + 3), "R9");

      // R3 / R4: index changes every cycle, data follows with no edge needed
      for (int i = 0; i < NR; i++)
         step(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 3'b001, 4'(i), 4'(i), 4'(i + 5), "R4");
      // R7: bank select picks the bank; equal indices differ between banks
      for (int i = 0; i < NR; i++)
         step(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 3'b110, 4'(i), 4'(i), 4'(i), "R7");

      // R5: same-cycle read of a register under write returns old data
      step(2'b01, 4'd3, 16'hBEEF, 4'd0, 16'h0, 3'b000, 4'd3, 4'd3, 4'd3, "R5");
      step(2'b10, 4'd0, 16'h0, 4'd9, 16'h1234, 3'b111, 4'd9, 4'd9, 4'd9, "R5");
      step(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 3'b010, 4'd3, 4'd9, 4'd3, "R3");

      // R6: disabled slots leave both banks untouched
      step(2'b00, 4'd4, 16'hDEAD, 4'd4, 16'hCAFE, 3'b010, 4'd4, 4'd4, 4'd2, "R6");
      step(2'b10, 4'd7, 16'h0BAD, 4'd7, 16'h7777, 3'b010, 4'd4, 4'd4, 4'd7, "R6");
      step(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 3'b010, 4'd7, 4'd7, 4'd4, "R6");

      // R2: slot 0 write at an index leaves bank 1's same index alone
      step(2'b01, 4'd12, 16'h4242, 4'd12, 16'h9999, 3'b000, 4'd1, 4'd1, 4'd1, "R2");
      step(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 3'b010, 4'd12, 4'd12, 4'd12, "R2");

      // R8: all ports on the same bank/index agree
      for (int i = 0; i < NR; i++) begin
         step(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 3'b000, 4'(i), 4'(i), 4'(i), "R8");
         step(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 3'b111, 4'(i), 4'(i), 4'(i), "R8");
      end

      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule